// File: doc/BRIEF.md
# Ethernet Frame Transmit Sequencer

This block steps a transmitter through one frame on a shared Ethernet segment. It sits in an idle state until the upstream path reports a frame ready, the line is quiet and the end-of-data flag is clear. It then passes through a data phase, where one word is fetched per word-done strobe, and a CRC phase. It returns to idle when the CRC finishes, when the next word arrives too late, or at once on a collision or a timeout.

The state is held in a 2-bit register that an active-low synchronous reset clears to idle. Code 0 is idle, 1 is data and 2 is CRC. The unused code 3 always moves to idle on the next clock. All control outputs are combinational from the present state and the present inputs. Serialising, CRC computation and collision detection are done outside this block.

Top module: `eth_tx_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state clears to idle (0). After reset, with all inputs low, `seq_idle` is 1 and `seq_busy` is 0.
- R2: The idle state moves to data (1) only when `frame_rdy` is 1, `medium_busy` is 0 and `data_end` is 0. In every other case it stays idle.
- R3: `tx_enable` equals NOT `collide` in the data and CRC states, and is 0 in idle.
- R4: `fetch_word` is 1 only in the data state, and only when `collide` is 0, `data_end` is 0, `word_strobe` is 1 and `frame_rdy` is 1.
- R5: In data, `word_strobe` with `data_end` high and `frame_rdy` high moves to CRC (2).
- R6: In data, `word_strobe` with `frame_rdy` low returns to idle, even when `data_end` is also high. Without `word_strobe`, data holds.
- R7: In data or CRC, `collide` or `tmo` forces a return to idle. This takes priority over every other transition.
- R8: In CRC, `word_strobe` returns to idle. Otherwise CRC holds.
- R9: `seq_idle` is 1 exactly when the next state is idle, and `seq_busy` is always its complement.
- R10: `done_n` is 0 exactly when the next state is idle and `collide` is 0.
- R11: `abort_n` is 0 exactly when `collide` is 1, in any state.
- R12: `seq_state` shows the registered state, which changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_rdy | input | 1 | A frame, or its next word, is available |
| medium_busy | input | 1 | Carrier sensed on the line |
| word_strobe | input | 1 | The current word has been sent |
| data_end | input | 1 | Last data word reached; also blocks the start of a frame |
| collide | input | 1 | Collision (jam) indication |
| tmo | input | 1 | Transmit timeout |
| tx_enable | output | 1 | Transmitter enable |
| fetch_word | output | 1 | Load the next data word |
| seq_idle | output | 1 | Next state is idle |
| seq_busy | output | 1 | Complement of seq_idle |
| done_n | output | 1 | Frame end without collision, active low |
| abort_n | output | 1 | Collision abort, active low |
| seq_state | output | 2 | Registered state code |

## Verification
Most outputs depend on both the state and the inputs, so a wrong state shows up as soon as any input pattern separates the two states. A lost CRC state, for example, would show `tx_enable` at 0 with `collide` low in the same cycle. An early exit to idle would drive `seq_idle` and `done_n` in the cycle the wrong transition is decided, one cycle before `seq_state` shows it. A bench model that tracks the state cycle by cycle under biased random inputs therefore catches a state error within one or two clocks.

// File: rtl/eth_tx_seq_pkg.sv
package eth_tx_seq_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CRC  = 2'd2,
    ST_RSVD = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic rdy;
    logic busy;
    logic strobe;
    logic last;
    logic jam;
    logic tmo;
  } seq_in_t;

  // Next state: the later assignments have the higher priority.
  function automatic seq_st_t step_state(seq_st_t s, seq_in_t i);
    seq_st_t n;
    n = s;
    case (s)
      ST_IDLE: if (i.rdy && !i.busy && !i.last) n = ST_DATA;
      ST_DATA: begin
        if (i.strobe && i.last) n = ST_CRC;
        if (i.strobe && !i.rdy) n = ST_IDLE;
        if (i.jam || i.tmo)     n = ST_IDLE;
      end
      ST_CRC: begin
        if (i.strobe)       n = ST_IDLE;
        if (i.jam || i.tmo) n = ST_IDLE;
      end
      default: n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic want_fetch(seq_st_t s, seq_in_t i);
    return (s == ST_DATA) && !i.jam && !i.last && i.strobe && i.rdy;
  endfunction

  function automatic logic want_drive(seq_st_t s, seq_in_t i);
    return ((s == ST_DATA) || (s == ST_CRC)) && !i.jam;
  endfunction

endpackage

// File: rtl/eth_tx_seq_next.sv
module eth_tx_seq_next
  import eth_tx_seq_pkg::*;
(
  input  seq_st_t cur_st,
  input  seq_in_t in_v,
  output seq_st_t nxt_st,
  output logic    drive,
  output logic    fetch
);
  always_comb begin
    nxt_st = step_state(cur_st, in_v);
    drive  = want_drive(cur_st, in_v);
    fetch  = want_fetch(cur_st, in_v);
  end
endmodule

// File: rtl/eth_tx_seq_decode.sv
module eth_tx_seq_decode
  import eth_tx_seq_pkg::*;
(
  input  seq_st_t nxt_st,
  input  logic    jam,
  output logic    idle_o,
  output logic    busy_o,
  output logic    done_no,
  output logic    abort_no
);
  logic going_idle;

  always_comb begin
    going_idle = (nxt_st == ST_IDLE);
    idle_o     = going_idle;
    busy_o     = !going_idle;
    done_no    = !(going_idle && !jam);
    abort_no   = !jam;
  end
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_rdy,
  input  logic            medium_busy,
  input  logic            word_strobe,
  input  logic            data_end,
  input  logic            collide,
  input  logic            tmo,
  output logic            tx_enable,
  output logic            fetch_word,
  output logic            seq_idle,
  output logic            seq_busy,
  output logic            done_n,
  output logic            abort_n,
  output logic [ST_W-1:0] seq_state
);
  seq_st_t st_q;
  seq_st_t st_d;
  seq_in_t in_v;

  // Named events for the assertions
  logic ev_start;
  logic ev_fault;
  logic ev_crc_end;

  assign in_v = '{rdy: frame_rdy, busy: medium_busy, strobe: word_strobe,
                  last: data_end, jam: collide, tmo: tmo};

  eth_tx_seq_next u_next (
    .cur_st (st_q),
    .in_v   (in_v),
    .nxt_st (st_d),
    .drive  (tx_enable),
    .fetch  (fetch_word)
  );

  eth_tx_seq_decode u_dec (
    .nxt_st   (st_d),
    .jam      (collide),
    .idle_o   (seq_idle),
    .busy_o   (seq_busy),
    .done_no  (done_n),
    .abort_no (abort_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign seq_state  = st_q;
  assign ev_start   = (st_q == ST_IDLE) && frame_rdy && !medium_busy && !data_end;
  assign ev_fault   = (st_q != ST_IDLE) && (collide || tmo);
  assign ev_crc_end = (st_q == ST_CRC) && word_strobe;

  AST_START_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (seq_state == 2'd1)); // R2
  AST_FAULT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (seq_state == 2'd0)); // R7
  AST_CRC_END: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc_end |=> (seq_state == 2'd0)); // R8
  AST_IDLE_PREDICTS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |=> (seq_state == 2'd0)); // R9
  AST_FETCH_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_word |-> (seq_state == 2'd1) && tx_enable); // R4
  AST_DRIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |-> (seq_state != 2'd0) && abort_n); // R3
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state != 2'd3); // R12
endmodule

// File: tb/eth_tx_seq_tb_top.sv
`timescale 1ns/1ps
module eth_tx_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic r = 0, c = 0, w = 0, inh = 0, j = 0, t = 0;
  logic go, ld, idl, bsy, dn_n, ab_n;
  logic [1:0] st;
  int total = 0, bad = 0;
  logic [1:0] mst = 2'd0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eth_tx_seq dut_i (
    .clk(clk), .rst_n(rst_n), .frame_rdy(r), .medium_busy(c), .word_strobe(w),
    .data_end(inh), .collide(j), .tmo(t), .tx_enable(go), .fetch_word(ld),
    .seq_idle(idl), .seq_busy(bsy), .done_n(dn_n), .abort_n(ab_n), .seq_state(st)
  );

  // Bench model: faults first, then data-late, then end of data.
  function automatic logic [1:0] m_next(logic [1:0] s);
    case (s)
      2'd0: return (r && !c && !inh) ? 2'd1 : 2'd0;
      2'd1: begin
        if (j || t)      return 2'd0;
        if (w && !r)     return 2'd0;
        if (w && inh)    return 2'd2;
        return 2'd1;
      end
      2'd2: return (j || t || w) ? 2'd0 : 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input logic ri, ci, wi, ii, ji, ti, input string tag);
    logic [1:0] n;
    @(negedge clk);
    r = ri; c = ci; w = wi; inh = ii; j = ji; t = ti;
    #1;
    n = m_next(mst);
    chk(st, mst, {"R12 state ", tag});
    chk({1'b0, go}, {1'b0, (mst == 2'd1 || mst == 2'd2) && !j}, "R3 tx_enable");
    chk({1'b0, ld}, {1'b0, mst == 2'd1 && !j && !inh && w && r}, "R4 fetch_word");
    chk({1'b0, idl}, {1'b0, n == 2'd0}, "R9 seq_idle");
    chk({1'b0, bsy}, {1'b0, n != 2'd0}, "R9 seq_busy");
    chk({1'b0, dn_n}, {1'b0, !(n == 2'd0 && !j)}, "R10 done_n");
    chk({1'b0, ab_n}, {1'b0, !j}, "R11 abort_n");
    mst = n;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(st, 2'd0, "R1 reset state");
    chk({1'b0, idl}, 2'd1, "R1 idle after reset");
    chk({1'b0, bsy}, 2'd0, "R1 busy after reset");
    // R2: blocked starts
    step(1,1,0,0,0,0, "R2 carrier blocks");
    step(1,0,0,1,0,0, "R2 end flag blocks");
    step(0,0,0,0,0,0, "R2 not ready");
    step(1,0,0,0,0,0, "R2 start");
    // data phase: hold, fetch, then end of data
    step(1,0,0,0,0,0, "R6 hold data");
    step(1,0,1,0,0,0, "R4 fetch");
    step(1,0,1,1,0,0, "R5 to crc");
    step(0,0,0,0,0,0, "R8 crc hold");
    step(0,0,1,0,0,0, "R8 crc end");
    // data late wins over end of data
    step(1,0,0,0,0,0, "R2 start");
    step(0,0,1,1,0,0, "R6 late");
    // collision in data overrides end of data
    step(1,0,0,0,0,0, "R2 start");
    step(1,0,1,1,1,0, "R7 jam in data");
    step(1,0,0,0,1,0, "R11 jam in idle");
    // timeout in crc
    step(1,0,0,0,0,0, "R2 start");
    step(1,0,1,1,0,0, "R5 to crc");
    step(0,0,0,0,0,1, "R7 timeout in crc");
    // random mix, biased toward ready and away from faults
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 2) == 0,
           ($urandom % 5) == 0, ($urandom % 12) == 0, ($urandom % 16) == 0,
           "R2/R5/R6/R7/R8 random");
    end
    // reset from a busy state
    step(1,0,0,0,0,0, "R2 start");
    @(negedge clk); rst_n = 1'b0; r = 1; c = 0; w = 0; inh = 0; j = 0; t = 0;
    @(negedge clk); rst_n = 1'b1; r = 0; #1;
    chk(st, 2'd0, "R1 reset mid frame");
    mst = 2'd0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule